// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a clock loop has settled. A reference clock and a feedback clock reach it as one-cycle edge strobes that are already synchronous to a fast sample clock. For each reference edge, the block looks for a feedback edge up to a programmable number of sample ticks before or after it. The block gives one verdict per reference edge: the edge is either in window (a hit) or out of window (a miss).

Hits are counted only while they are consecutive. When the run reaches a programmable target length, the lock output goes high. A single miss clears both the run count and the lock output in the same cycle. The window half-width and the target length are taken from input pins while reset is held, and the block keeps those values until the next reset. The run count is available as an output so that loop-settling progress can be observed.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `locked` is 0 and `run_cnt` is 0. `rst` is synchronous and active high.
- R2: A feedback strobe that lies at most `win_in` sample cycles before, at, or after a reference strobe makes that reference a hit. A distance of `win_in`+1 cycles on either side makes it a miss.
- R3: If no feedback strobe arrives within `win_in` cycles after a reference strobe, and none was available before it, that reference is a miss. The miss verdict is taken in the cycle `win_in` cycles after the reference strobe.
- R4: Each hit raises `run_cnt` by exactly one, starting from 0. The count only starts moving on the first hit after reset or after a miss.
- R5: `locked` rises in the cycle right after the verdict that brings `run_cnt` to the target `need_in`. It never rises earlier.
- R6: When `run_cnt` equals the target, further hits hold `run_cnt` at the target and keep `locked` high. `run_cnt` never exceeds the target.
- R7: A miss sets `run_cnt` to 0 and `locked` to 0, both visible in the cycle after the miss verdict.
- R8: A feedback strobe gives credit to at most one reference strobe. A reference that only has an already-used feedback strobe nearby is a miss.
- R9: `win_in` and `need_in` are captured while `rst` is high. Changes to them after reset have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset; also captures the configuration |
| ref_evt | input | 1 | One-cycle strobe for a reference clock edge |
| fb_evt | input | 1 | One-cycle strobe for a feedback clock edge |
| win_in | input | WIN_W | Window half-width in sample ticks |
| need_in | input | CNT_W | Number of consecutive hits required for lock |
| locked | output | 1 | Lock indication |
| run_cnt | output | CNT_W | Current length of the run of consecutive hits |

## Verification
The embedded assertions check the following on every cycle: the count never exceeds the target, lock always goes with a full count, a miss clears count and lock on the next cycle, each hit below the target adds exactly one, and a waiting window never runs past its width. The bench scenarios are needed for the rest: the exact placement of the window edges on both sides of the reference, the cycle in which a missing feedback edge turns into a miss, the single use of each feedback edge, and the fact that the configuration pins are ignored outside reset. These all depend on how strobes are spaced relative to each other, which only scripted offsets can set up.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

   // Outcome of judging one reference edge
   typedef enum logic [1:0] {
      VERD_NONE = 2'd0,
      VERD_HIT  = 2'd1,
      VERD_MISS = 2'd2
   } verdict_t;

endpackage

// File: rtl/lkd_fb_tracker.sv
// Remembers the most recent feedback edge: its age in ticks and whether
// it is still unclaimed by a reference edge.
module lkd_fb_tracker #(
   parameter int AGE_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fb_evt,
   input  logic             claim,
   output logic [AGE_W-1:0] fb_age,
   output logic             fb_avail
);

   localparam logic [AGE_W-1:0] AGE_SAT = {AGE_W{1'b1}};

   always_ff @(posedge clk) begin
      if (rst) begin
         fb_age   <= AGE_SAT;
         fb_avail <= 1'b0;
      end else if (fb_evt) begin
         fb_age   <= {{(AGE_W-1){1'b0}}, 1'b1};
         fb_avail <= !claim;
      end else begin
         if (fb_age != AGE_SAT) begin
            fb_age <= fb_age + 1'b1;
         end
         if (claim) begin
            fb_avail <= 1'b0;
         end
      end
   end

   // R8
   claim_spends_chk: assert property (@(posedge clk) disable iff (rst)
      (claim && !fb_evt) |=> !fb_avail);

endmodule

// File: rtl/lkd_window_judge.sv
// Gives one verdict per reference edge: an early feedback edge that is
// still inside the window, or a late one arriving before the window closes.
module lkd_window_judge
   import lkd_pkg::*;
#(
   parameter int WIN_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_evt,
   input  logic             fb_evt,
   input  logic             fb_avail,
   input  logic [WIN_W:0]   fb_age,
   input  logic [WIN_W-1:0] win,
   output verdict_t         verdict,
   output logic             claim
);

   logic             pend_q, pend_n;
   logic [WIN_W-1:0] wait_q, wait_n;
   logic             early_ok;

   assign early_ok = fb_evt || (fb_avail && (fb_age <= {1'b0, win}));

   always_comb begin
      verdict = VERD_NONE;
      claim   = 1'b0;
      pend_n  = pend_q;
      wait_n  = wait_q;
      if (pend_q) begin
         if (ref_evt) begin
            // a new reference edge while waiting: the old one failed
            verdict = VERD_MISS;
            pend_n  = 1'b0;
         end else if (fb_evt) begin
            verdict = VERD_HIT;
            claim   = 1'b1;
            pend_n  = 1'b0;
         end else if (wait_q >= win) begin
            verdict = VERD_MISS;
            pend_n  = 1'b0;
         end else begin
            wait_n = wait_q + 1'b1;
         end
      end else if (ref_evt) begin
         if (early_ok) begin
            verdict = VERD_HIT;
            claim   = 1'b1;
         end else if (win == '0) begin
            verdict = VERD_MISS;
         end else begin
            pend_n = 1'b1;
            wait_n = {{(WIN_W-1){1'b0}}, 1'b1};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         wait_q <= '0;
      end else begin
         pend_q <= pend_n;
         wait_q <= wait_n;
      end
   end

   // R3
   wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
      pend_q |-> (wait_q <= win));

   // R3
   wait_from_ref_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q) |-> $past(ref_evt));

endmodule

// File: rtl/lkd_run_counter.sv
// Counts consecutive hits up to the target and drives the lock flag.
module lkd_run_counter
   import lkd_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  verdict_t         verdict,
   input  logic [CNT_W-1:0] need,
   output logic [CNT_W-1:0] run_cnt,
   output logic             locked
);

   logic [CNT_W:0] cnt_up;

   assign cnt_up = {1'b0, run_cnt} + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt <= '0;
         locked  <= 1'b0;
      end else begin
         unique case (verdict)
            VERD_MISS: begin
               run_cnt <= '0;
               locked  <= 1'b0;
            end
            VERD_HIT: begin
               if (run_cnt < need) begin
                  run_cnt <= cnt_up[CNT_W-1:0];
                  locked  <= (cnt_up >= {1'b0, need});
               end else begin
                  locked <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // R7
   miss_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (verdict == VERD_MISS) |=> (run_cnt == '0) && !locked);

   // R4
   hit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (verdict == VERD_HIT && run_cnt < need) |=>
         (run_cnt == CNT_W'($past(run_cnt) + 1'b1)));

   // R5
   lock_at_target_chk: assert property (@(posedge clk) disable iff (rst)
      locked |-> (run_cnt == need));

   // R6
   no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
      run_cnt <= need);

   // R6
   hold_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (verdict == VERD_HIT && run_cnt == need) |=> locked);

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
   import lkd_pkg::*;
#(
   parameter int WIN_W    = 6,
   parameter int CNT_W    = 8,
   parameter bit CFG_HOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_evt,
   input  logic             fb_evt,
   input  logic [WIN_W-1:0] win_in,
   input  logic [CNT_W-1:0] need_in,
   output logic             locked,
   output logic [CNT_W-1:0] run_cnt
);

   localparam int AGE_W = WIN_W + 1;

   if (WIN_W < 1 || WIN_W > 16) begin : g_bad_win
      $error("pll_lock_detect: WIN_W must be in 1..16");
   end
   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
      $error("pll_lock_detect: CNT_W must be in 1..24");
   end

   logic [WIN_W-1:0] win_q;
   logic [CNT_W-1:0] need_q;

   if (CFG_HOLD) begin : g_cfg_hold
      always_ff @(posedge clk) begin
         if (rst) begin
            win_q  <= win_in;
            need_q <= need_in;
         end
      end
   end else begin : g_cfg_live
      assign win_q  = win_in;
      assign need_q = need_in;
   end

   logic [AGE_W-1:0] fb_age;
   logic             fb_avail;
   logic             claim;
   verdict_t         verdict;

   lkd_fb_tracker #(.AGE_W(AGE_W)) u_fb (
      .clk      (clk),
      .rst      (rst),
      .fb_evt   (fb_evt),
      .claim    (claim),
      .fb_age   (fb_age),
      .fb_avail (fb_avail)
   );

   lkd_window_judge #(.WIN_W(WIN_W)) u_judge (
      .clk      (clk),
      .rst      (rst),
      .ref_evt  (ref_evt),
      .fb_evt   (fb_evt),
      .fb_avail (fb_avail),
      .fb_age   (fb_age),
      .win      (win_q),
      .verdict  (verdict),
      .claim    (claim)
   );

   lkd_run_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .verdict (verdict),
      .need    (need_q),
      .run_cnt (run_cnt),
      .locked  (locked)
   );

endmodule

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb;

   localparam int WIN_W = 6;
   localparam int CNT_W = 8;
   localparam int PER   = 40;
   localparam int MID   = 20;
   localparam int NV    = 16;

   // window 3, target 4; offset = fb tick minus ref tick
   localparam int V_OFF [0:NV-1] = '{ 0, -3,  3,  2, -1,  4, -2,  0,
                                      1, -4,  3, -3,  0,  1,  0, -5};
   localparam int V_HAS [0:NV-1] = '{ 1,  1,  1,  1,  1,  1,  1,  0,
                                      1,  1,  1,  1,  1,  1,  1,  1};
   localparam int V_CNT [0:NV-1] = '{ 1,  2,  3,  4,  4,  0,  1,  0,
                                      1,  0,  1,  2,  3,  4,  4,  0};
   localparam int V_LCK [0:NV-1] = '{ 0,  0,  0,  1,  1,  0,  0,  0,
                                      0,  0,  0,  0,  0,  1,  1,  0};

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             ref_evt = 1'b0;
   logic             fb_evt = 1'b0;
   logic [WIN_W-1:0] win_in = 6'd3;
   logic [CNT_W-1:0] need_in = 8'd4;
   logic             locked;
   logic [CNT_W-1:0] run_cnt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pll_lock_detect #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .ref_evt (ref_evt),
      .fb_evt  (fb_evt),
      .win_in  (win_in),
      .need_in (need_in),
      .locked  (locked),
      .run_cnt (run_cnt)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic f);
      @(negedge clk);
      ref_evt = r;
      fb_evt  = f;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc(1'b0, 1'b0);
   endtask

   task automatic do_reset(input int w, input int n);
      @(negedge clk);
      rst     = 1'b1;
      win_in  = WIN_W'(w);
      need_in = CNT_W'(n);
      idle(3);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset(3, 4);
      chk("R1 reset locked", int'(locked), 0);
      chk("R1 reset count", int'(run_cnt), 0);

      // vector walk: one reference period per entry
      for (int i = 0; i < NV; i++) begin
         for (int c = 0; c < PER; c++) begin
            cyc(c == MID, (V_HAS[i] != 0) && (c == MID + V_OFF[i]));
         end
         @(negedge clk);
         chk($sformatf("R2/R4/R6/R7 vec%0d count", i), int'(run_cnt), V_CNT[i]);
         chk($sformatf("R3/R5/R7 vec%0d lock", i), int'(locked), V_LCK[i]);
      end

      // window 2, target 2
      do_reset(2, 2);

      // R4 late feedback at the window edge: count changes exactly then
      cyc(1, 0); cyc(0, 0); cyc(0, 1);
      chk("R4 before late hit", int'(run_cnt), 0);
      cyc(0, 0);
      chk("R4 after late hit", int'(run_cnt), 1);
      idle(5);

      // R5 lock rises on the cycle after the target-reaching verdict
      cyc(1, 0); cyc(0, 0); cyc(0, 1);
      chk("R5 lock before nth hit", int'(locked), 0);
      cyc(0, 0);
      chk("R5 lock after nth hit", int'(locked), 1);
      chk("R5 count at target", int'(run_cnt), 2);
      idle(5);

      // R3 missing feedback: miss taken win ticks after the reference
      cyc(1, 0); cyc(0, 0); cyc(0, 0);
      chk("R3 lock held inside window", int'(locked), 1);
      cyc(0, 0);
      chk("R7 lock dropped on miss", int'(locked), 0);
      chk("R7 count cleared on miss", int'(run_cnt), 0);
      idle(5);

      // R8 one feedback edge cannot serve two references
      cyc(1, 0); cyc(0, 1); cyc(1, 0);
      chk("R8 first ref credited", int'(run_cnt), 1);
      cyc(0, 0); cyc(0, 0); cyc(0, 0);
      chk("R8 reused feedback rejected", int'(run_cnt), 0);
      idle(5);

      // R2 early feedback exactly win ticks before the reference
      cyc(0, 1); cyc(0, 0); cyc(1, 0); cyc(0, 0);
      chk("R2 early edge at window limit", int'(run_cnt), 1);
      idle(5);

      // R9 widened window pin after reset is ignored
      win_in = 6'd7;
      cyc(1, 0); idle(4); cyc(0, 1); cyc(0, 0);
      chk("R9 stale window kept", int'(run_cnt), 0);
      idle(5);

      // R1 reset while locked
      cyc(1, 1); idle(3); cyc(1, 1); idle(2);
      chk("R2 same-cycle edges lock", int'(locked), 1);
      do_reset(7, 2);
      chk("R1 reset clears lock", int'(locked), 0);
      chk("R1 reset clears count", int'(run_cnt), 0);

      // R9 new window applies after reset: offset 5 now hits
      cyc(1, 0); idle(4); cyc(0, 1); cyc(0, 0);
      chk("R9 new window after reset", int'(run_cnt), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule